// File: doc/BRIEF.md
# Level Interrupt Controller with Auto-Ack

The block collects a set of level-sensitive hardware interrupt lines and steers each one to one or more CPUs. Every line carries a mask bit, a software-trigger bit and a routing word with one bit per CPU. All of this state is programmed over a simple 32-bit register bus. Every bus access carries the index of the issuing CPU, so the same address can give each CPU its own view.

A line is pending when its hardware input or its software-trigger bit is high. It is deliverable to CPU c when it is pending, its mask bit is clear and routing bit c is set. Each CPU has a level output that is high while any line is deliverable to it. The CPU services it by reading its event register. That read returns the lowest-numbered deliverable line, tagged with the hardware event code. The same read sets that line's mask bit, which acknowledges the line. The handler then clears the mask bit at the end of service.

Top module: `lic_top`

## Requirements
- R1: After reset every mask bit is 1, every software-trigger bit is 0, every routing word is 0 and irq_o is all zero.
- R2: Mask bits for line n sit in word n>>5, bit n&31. Writing a one to 0x4100+4*(n>>5) sets the bit. Writing a one to 0x4180+4*(n>>5) clears it. Zero bits in the write data leave bits unchanged. A read of either address returns the mask word.
- R3: Software-trigger bits use the same word and bit layout, with set at 0x4000 and clear at 0x4080. A set trigger bit makes its line pending exactly as a high hardware input does. A read of either address returns the trigger word.
- R4: The routing word of line n is at 0x3000+4*n. Bit c of that word lets CPU c see the line. A CPU whose bit is 0 never sees the line.
- R5: A read of the event register at 0x2004 returns 1 in bits 31:16 and the line number in bits 15:0. When several deliverable lines target the reading CPU, the lowest-numbered line is returned.
- R6: An event read that returns a line sets that line's mask bit at the same clock edge. irq_o of that CPU then drops once no other deliverable line targets it.
- R7: An event read that finds nothing deliverable returns 0 and changes no state.
- R8: A read of 0x0004 returns the number of lines in bits 15:0.
- R9: A read of 0x2000 returns the index of the accessing CPU.
- R10: irq_o[c] follows the levels without delay. It is high exactly while some unmasked pending line routes to CPU c, and it falls when the hardware input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_irq_i | input | NUM_LINES | Level interrupt inputs |
| bus_req_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_cpu_i | input | CPU_W | Index of the accessing CPU |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address and state |
| irq_o | output | NUM_CPUS | Per-CPU interrupt level |

## Verification
The bench builds the block with its defaults: 64 lines and 4 CPUs. Two mask and trigger words therefore exist, so the tests cover the word index as well as the bit index, and they use the top line 63. Four CPUs make it possible to show that a line routed to one CPU stays invisible to another. Priority is checked with two lines in the upper word, and auto-acknowledge is checked by reading the mask back over the bus.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_INFO   = 16'h0004;
  localparam logic [ADDR_W-1:0] A_WHOAMI = 16'h2000;
  localparam logic [ADDR_W-1:0] A_EVENT  = 16'h2004;
  localparam logic [3:0]        A_TGT_HI = 4'h3;     // 0x3000 region
  localparam logic [6:0]        A_ARR_HI = 7'h20;    // 0x4000..0x41FF
  localparam logic [15:0]       EVT_HW   = 16'd1;

  typedef enum logic [1:0] {
    ARR_SW_SET   = 2'b00,
    ARR_SW_CLR   = 2'b01,
    ARR_MASK_SET = 2'b10,
    ARR_MASK_CLR = 2'b11
  } arr_op_e;
endpackage

// File: rtl/lic_bitreg.sv
module lic_bitreg #(
  parameter int N       = 64,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= {N{RST_ONE}};
    else         q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/lic_prio_enc.sv
module lic_prio_enc #(
  parameter int N     = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |vec_i;

  // R5: chosen bit is set and nothing below it is set
  a_r5_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (vec_i[idx_o] && ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0)));
endmodule

// File: rtl/lic_top.sv
module lic_top
  import lic_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] hw_irq_i,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [CPU_W-1:0]     bus_cpu_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NUM_CPUS-1:0]  irq_o
);
  localparam int WORDS  = (NUM_LINES + 31) / 32;
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int WIDE   = WORDS * 32;

  // decode
  logic            arr_hit, tgt_hit, evt_rd;
  arr_op_e         arr_op;
  logic [4:0]      arr_word;
  logic [9:0]      tgt_line;
  logic [WIDE-1:0] wr_wide;

  assign arr_hit  = bus_req_i && (bus_addr_i[15:9] == A_ARR_HI) &&
                    (32'(bus_addr_i[6:2]) < WORDS);
  assign arr_op   = arr_op_e'(bus_addr_i[8:7]);
  assign arr_word = bus_addr_i[6:2];
  assign tgt_line = bus_addr_i[11:2];
  assign tgt_hit  = bus_req_i && (bus_addr_i[15:12] == A_TGT_HI) &&
                    (32'(tgt_line) < NUM_LINES);
  assign evt_rd   = bus_req_i && !bus_we_i && (bus_addr_i == A_EVENT);

  always_comb begin
    wr_wide = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (32'(arr_word) == w) wr_wide[w*32 +: 32] = bus_wdata_i;
    end
  end

  logic [NUM_LINES-1:0] wr_bits;
  assign wr_bits = wr_wide[NUM_LINES-1:0];

  logic arr_wr;
  assign arr_wr = arr_hit && bus_we_i;

  // per-line state
  logic [NUM_LINES-1:0] mask_q, sw_q, ack_vec;
  logic [NUM_LINES-1:0] mask_set, mask_clr, sw_set, sw_clr;

  assign sw_set   = (arr_wr && arr_op == ARR_SW_SET)   ? wr_bits : '0;
  assign sw_clr   = (arr_wr && arr_op == ARR_SW_CLR)   ? wr_bits : '0;
  assign mask_set = ((arr_wr && arr_op == ARR_MASK_SET) ? wr_bits : '0) | ack_vec;
  assign mask_clr = (arr_wr && arr_op == ARR_MASK_CLR) ? wr_bits : '0;

  lic_bitreg #(.N(NUM_LINES), .RST_ONE(1'b1)) u_mask (
    .clk_i, .rst_ni, .set_i(mask_set), .clr_i(mask_clr), .q_o(mask_q));
  lic_bitreg #(.N(NUM_LINES), .RST_ONE(1'b0)) u_sw (
    .clk_i, .rst_ni, .set_i(sw_set), .clr_i(sw_clr), .q_o(sw_q));

  logic [NUM_CPUS-1:0] tgt_q [NUM_LINES];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_LINES; n++) tgt_q[n] <= '0;
    end else if (tgt_hit && bus_we_i) begin
      tgt_q[tgt_line[LINE_W-1:0]] <= bus_wdata_i[NUM_CPUS-1:0];
    end
  end

  // per-CPU selection
  logic [NUM_LINES-1:0] live;
  assign live = (hw_irq_i | sw_q) & ~mask_q;

  logic [NUM_CPUS-1:0] found;
  logic [LINE_W-1:0]   sel [NUM_CPUS];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_LINES-1:0] cand;
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_ln
      assign cand[n] = live[n] & tgt_q[n][c];
    end
    lic_prio_enc #(.N(NUM_LINES)) u_enc (
      .clk_i, .rst_ni, .vec_i(cand), .found_o(found[c]), .idx_o(sel[c]));
  end
  assign irq_o = found;

  logic              cur_found;
  logic [LINE_W-1:0] cur_idx;
  assign cur_found = found[bus_cpu_i];
  assign cur_idx   = sel[bus_cpu_i];
  assign ack_vec   = (evt_rd && cur_found) ? (NUM_LINES'(1) << cur_idx) : '0;

  // read mux
  logic [WIDE-1:0] mask_wide, sw_wide;
  assign mask_wide = WIDE'(mask_q);
  assign sw_wide   = WIDE'(sw_q);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      if (bus_addr_i == A_INFO) begin
        bus_rdata_o = {16'd0, 16'(NUM_LINES)};
      end else if (bus_addr_i == A_WHOAMI) begin
        bus_rdata_o = DATA_W'(bus_cpu_i);
      end else if (evt_rd) begin
        if (cur_found) bus_rdata_o = {EVT_HW, 16'(cur_idx)};
      end else if (tgt_hit) begin
        bus_rdata_o = DATA_W'(tgt_q[tgt_line[LINE_W-1:0]]);
      end else if (arr_hit) begin
        if (arr_op == ARR_SW_SET || arr_op == ARR_SW_CLR)
          bus_rdata_o = sw_wide[32*arr_word +: 32];
        else
          bus_rdata_o = mask_wide[32*arr_word +: 32];
      end
    end
  end

  // assertions
  logic [NUM_LINES*NUM_CPUS-1:0] tgt_flat;
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_flat
    assign tgt_flat[n*NUM_CPUS +: NUM_CPUS] = tgt_q[n];
  end

  a_r6_ack_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rd && bus_rdata_o[31:16] == EVT_HW) |=> mask_q[$past(bus_rdata_o[LINE_W-1:0])]);

  a_r7_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rd && !irq_o[bus_cpu_i]) |-> (bus_rdata_o == '0));

  a_r7_empty_read_keeps_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rd && !irq_o[bus_cpu_i]) |=> $stable(mask_q));

  a_r4_route_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tgt_hit && bus_we_i) |=> $stable(tgt_flat));

  a_r10_masked_line_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> (irq_o == '0));
endmodule

// File: tb/lic_top_tb.sv
module lic_top_tb;
  localparam int CLK_P  = 10;
  localparam int NL     = 64;
  localparam int NC     = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NL-1:0] hw_irq = '0;
  logic          req = 0, we = 0;
  logic [1:0]    cpu = '0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NC-1:0] irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lic_top #(.NUM_LINES(NL), .NUM_CPUS(NC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_irq_i(hw_irq), .bus_req_i(req),
    .bus_we_i(we), .bus_cpu_i(cpu), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(logic [1:0] c, logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; cpu = c;
    #(CLK_P/4);
    d = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    rd(0, 16'h4100, d); check("R1 mask w0", d, 32'hFFFF_FFFF);
    rd(0, 16'h4104, d); check("R1 mask w1", d, 32'hFFFF_FFFF);
    rd(0, 16'h4004, d); check("R1 sw w1", d, 0);
    rd(0, 16'h3014, d); check("R1 target 5", d, 0);
    rd(0, 16'h2004, d); check("R7 empty event", d, 0);
  endtask

  task automatic t_ids();
    logic [31:0] d;
    rd(0, 16'h0004, d); check("R8 info", d, 64);
    rd(2, 16'h2000, d); check("R9 whoami cpu2", d, 2);
    rd(3, 16'h2000, d); check("R9 whoami cpu3", d, 3);
  endtask

  task automatic t_route_ack();
    logic [31:0] d;
    @(negedge clk); hw_irq[5] = 1;
    wr(16'h3014, 32'h2);
    check("R1 masked line silent", 32'(irq), 0);
    wr(16'h4180, 32'h20);
    check("R4 R10 irq cpu1", 32'(irq), 32'h2);
    rd(0, 16'h4100, d); check("R2 mask clear", d, 32'hFFFF_FFDF);
    rd(0, 16'h2004, d); check("R4 other cpu sees none", d, 0);
    rd(1, 16'h2004, d); check("R5 event line5", d, 32'h0001_0005);
    check("R6 irq drops", 32'(irq), 0);
    rd(0, 16'h4100, d); check("R6 auto mask", d, 32'hFFFF_FFFF);
    wr(16'h4180, 32'h20);
    check("R10 irq back", 32'(irq), 32'h2);
    @(negedge clk); hw_irq[5] = 0; #1;
    check("R10 level drop", 32'(irq), 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(16'h3084, 32'h8);
    wr(16'h30A0, 32'h8);
    wr(16'h4004, 32'h102);
    rd(0, 16'h4004, d); check("R3 sw set", d, 32'h102);
    check("R3 masked sw silent", 32'(irq), 0);
    wr(16'h4184, 32'h102);
    check("R3 sw irq cpu3", 32'(irq), 32'h8);
    rd(3, 16'h2004, d); check("R5 lowest 33", d, 32'h0001_0021);
    check("R6 still 40", 32'(irq), 32'h8);
    rd(3, 16'h2004, d); check("R5 next 40", d, 32'h0001_0028);
    check("R6 drop", 32'(irq), 0);
    rd(3, 16'h2004, d); check("R7 empty", d, 0);
    rd(3, 16'h4104, d); check("R7 mask unchanged", d, 32'hFFFF_FFFF);
    wr(16'h4084, 32'h102);
    rd(0, 16'h4084, d); check("R3 sw clr", d, 0);
  endtask

  task automatic t_top_line();
    logic [31:0] d;
    wr(16'h30FC, 32'h1);
    wr(16'h4004, 32'h8000_0000);
    wr(16'h4184, 32'h8000_0000);
    check("R3 line63 irq", 32'(irq), 32'h1);
    rd(0, 16'h4104, d); check("R2 word1 bit31", d, 32'h7FFF_FFFF);
    wr(16'h4084, 32'h8000_0000);
    check("R3 sw clear drops", 32'(irq), 0);
    wr(16'h4104, 32'h8000_0000);
    rd(0, 16'h4104, d); check("R2 mask set", d, 32'hFFFF_FFFF);
    rd(0, 16'h30FC, d); check("R4 target readback", d, 1);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_ids();
    t_route_ack();
    t_prio();
    t_top_line();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule